// File: doc/BRIEF.md
# Profile Register Bank Selector

This block keeps eight parameter sets for a synthesis datapath. Each set holds a 32-bit frequency tuning word, a 16-bit phase offset and a 14-bit amplitude scale. Software writes the sets through a simple staging write port. Three external select pins choose which set drives the active outputs.

Staged values are double-buffered. A write to a staging register does not reach the active outputs by itself. The staged contents of the selected set are copied to the active outputs only on a transfer event. A transfer event is either a rising edge of the update strobe or any change of the select pins.

The select pins and the update strobe are asynchronous, so each passes through a two-flop synchronizer before edge or change detection. A small state machine has two states. It moves from `ST_IDLE` to `ST_APPLY` on a transfer event (transition *arm*). It stays in `ST_APPLY` when another event follows at once (transition *rearm*). It returns to `ST_IDLE` when no event follows (transition *settle*). It stays in `ST_IDLE` when nothing happens (transition *wait*). While the machine is in `ST_APPLY`, it drives a profile-change pulse that other blocks can use to decide on reloads.

Two-tone frequency shift keying works by loading different tuning words into sets 0 and 1, holding the upper two select pins low, and toggling only the lowest pin.

Top module: `prof_bank_sel`

## Requirements
- R1: While reset is asserted, and until the first transfer event after it, the active tuning word, phase offset, amplitude scale and active index are all zero, and the change pulse is low.
- R2: A staging write changes nothing at the active outputs until a later transfer event. After that event the written value appears.
- R3: A rising edge of the update strobe is a transfer event. If the strobe changes between clock edges, the active outputs hold the selected set's staged contents, and the change pulse is high, after the third following rising clock edge.
- R4: An update strobe that stays high, or falls, starts no further transfer. Only its rising edge counts.
- R5: Any change of the 3-bit select pins is a transfer event with the same three-edge latency as R3. The active index equals the pins read as an unsigned binary number.
- R6: For an isolated transfer event, the change pulse is high for exactly one clock cycle.
- R7: If a staging write to the profile being transferred is captured on the same clock edge that loads the active outputs, the active outputs take the value from before the write. The new value stays staged for the next transfer.
- R8: With sets 0 and 1 holding different tuning words and the upper two pins low, each toggle of the lowest select pin switches the active tuning word between the two sets.
- R9: All eight sets can be reached: pin code 000 selects set 0 and pin code 111 selects set 7, and every set keeps its own three fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Staging write strobe, one write per cycle |
| wr_idx | input | 3 | Index of the set being written |
| wr_ftw | input | 32 | Tuning word to stage |
| wr_pow | input | 16 | Phase offset to stage |
| wr_asf | input | 14 | Amplitude scale to stage |
| sel_pins | input | 3 | Asynchronous profile select pins |
| upd_in | input | 1 | Asynchronous update strobe |
| act_ftw | output | 32 | Active tuning word |
| act_pow | output | 16 | Active phase offset |
| act_asf | output | 14 | Active amplitude scale |
| act_idx | output | 3 | Index of the set now active |
| prof_chg | output | 1 | One-cycle pulse after each transfer |

## Verification
The hardest case to reach from the ports is a staging write that lands on the same clock edge as a transfer load (R7). From the pins, that edge sits behind the synchronizer and the change detector. The bench changes the select pins just after a falling edge and counts two rising edges. It then presents the write to the newly selected set, so the write is captured on the third edge, which is exactly when the active registers load. It checks that the old value appears at the outputs. A later update strobe must then bring out the new value.

// File: rtl/prof_pkg.sv
package prof_pkg;

    // Sequencer states of the transfer controller
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,
        ST_APPLY = 1'b1
    } prof_state_e;

endpackage

// File: rtl/prof_sync.sv
module prof_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] chain_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain_q[i] <= '0;
        end else begin
            chain_q[0] <= d;
            for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
        end
    end

    assign q = chain_q[STAGES-1];

endmodule

// File: rtl/prof_evt_fsm.sv
module prof_evt_fsm #(
    parameter int IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] sel_s,
    input  logic             upd_s,
    output logic             load_en,
    output logic [IDX_W-1:0] load_idx,
    output logic             chg_pulse
);
    import prof_pkg::*;

    prof_state_e      state_q, state_d;
    logic [IDX_W-1:0] sel_prev_q;
    logic             upd_prev_q;
    logic             pin_chg, upd_rise, evt;

    // Previous synchronized values for edge and change detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_prev_q <= '0;
            upd_prev_q <= 1'b0;
        end else begin
            sel_prev_q <= sel_s;
            upd_prev_q <= upd_s;
        end
    end

    assign pin_chg  = (sel_s != sel_prev_q);
    assign upd_rise = upd_s & ~upd_prev_q;
    assign evt      = pin_chg | upd_rise;

    // Next-state: arm / rearm / settle / wait
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  state_d = evt ? ST_APPLY : ST_IDLE;
            ST_APPLY: state_d = evt ? ST_APPLY : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        load_en   = evt;
        load_idx  = sel_s;
        chg_pulse = (state_q == ST_APPLY);
    end

    // R3: a rising update strobe always produces a change pulse next cycle
    p_rise_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_s && !$past(upd_s)) |=> chg_pulse);

    // R4: a held strobe with steady pins gives no pulse
    p_level_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_s && $past(upd_s) && sel_s == $past(sel_s)) |=> !chg_pulse);

endmodule

// File: rtl/prof_bank.sv
module prof_bank #(
    parameter int N     = 8,
    parameter int IDX_W = 3,
    parameter int FTW_W = 32,
    parameter int POW_W = 16,
    parameter int ASF_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [FTW_W-1:0] wr_ftw,
    input  logic [POW_W-1:0] wr_pow,
    input  logic [ASF_W-1:0] wr_asf,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [FTW_W-1:0] rd_ftw,
    output logic [POW_W-1:0] rd_pow,
    output logic [ASF_W-1:0] rd_asf
);

    logic [FTW_W-1:0] stg_ftw [N];
    logic [POW_W-1:0] stg_pow [N];
    logic [ASF_W-1:0] stg_asf [N];

    generate
        for (genvar g = 0; g < N; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stg_ftw[g] <= '0;
                    stg_pow[g] <= '0;
                    stg_asf[g] <= '0;
                end else if (wr_en && wr_idx == IDX_W'(g)) begin
                    stg_ftw[g] <= wr_ftw;
                    stg_pow[g] <= wr_pow;
                    stg_asf[g] <= wr_asf;
                end
            end
        end
    endgenerate

    // Read returns the contents before any write on the same edge
    always_comb begin
        rd_ftw = '0;
        rd_pow = '0;
        rd_asf = '0;
        for (int i = 0; i < N; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                rd_ftw = stg_ftw[i];
                rd_pow = stg_pow[i];
                rd_asf = stg_asf[i];
            end
        end
    end

    // R2: a write lands in the addressed staging slot
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && 32'(wr_idx) < N) |=> stg_ftw[$past(wr_idx)] == $past(wr_ftw));

endmodule

// File: rtl/prof_active.sv
module prof_active #(
    parameter int IDX_W = 3,
    parameter int FTW_W = 32,
    parameter int POW_W = 16,
    parameter int ASF_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [IDX_W-1:0] load_idx,
    input  logic [FTW_W-1:0] in_ftw,
    input  logic [POW_W-1:0] in_pow,
    input  logic [ASF_W-1:0] in_asf,
    output logic [FTW_W-1:0] out_ftw,
    output logic [POW_W-1:0] out_pow,
    output logic [ASF_W-1:0] out_asf,
    output logic [IDX_W-1:0] out_idx
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_ftw <= '0;
            out_pow <= '0;
            out_asf <= '0;
            out_idx <= '0;
        end else if (load_en) begin
            out_ftw <= in_ftw;
            out_pow <= in_pow;
            out_asf <= in_asf;
            out_idx <= load_idx;
        end
    end

endmodule

// File: rtl/prof_bank_sel.sv
module prof_bank_sel #(
    parameter int NUM_PROF    = 8,
    parameter int FTW_W       = 32,
    parameter int POW_W       = 16,
    parameter int ASF_W       = 14,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [$clog2(NUM_PROF)-1:0] wr_idx,
    input  logic [FTW_W-1:0]            wr_ftw,
    input  logic [POW_W-1:0]            wr_pow,
    input  logic [ASF_W-1:0]            wr_asf,
    input  logic [$clog2(NUM_PROF)-1:0] sel_pins,
    input  logic                        upd_in,
    output logic [FTW_W-1:0]            act_ftw,
    output logic [POW_W-1:0]            act_pow,
    output logic [ASF_W-1:0]            act_asf,
    output logic [$clog2(NUM_PROF)-1:0] act_idx,
    output logic                        prof_chg
);
    localparam int IDX_W = $clog2(NUM_PROF);

    logic [IDX_W-1:0] sel_sync;
    logic             upd_sync;
    logic             load_en;
    logic [IDX_W-1:0] load_idx;
    logic [FTW_W-1:0] rd_ftw;
    logic [POW_W-1:0] rd_pow;
    logic [ASF_W-1:0] rd_asf;

    prof_sync #(.W(IDX_W), .STAGES(SYNC_STAGES)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .d(sel_pins), .q(sel_sync));

    prof_sync #(.W(1), .STAGES(SYNC_STAGES)) u_upd_sync (
        .clk(clk), .rst_n(rst_n), .d(upd_in), .q(upd_sync));

    prof_evt_fsm #(.IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .sel_s(sel_sync), .upd_s(upd_sync),
        .load_en(load_en), .load_idx(load_idx), .chg_pulse(prof_chg));

    prof_bank #(.N(NUM_PROF), .IDX_W(IDX_W), .FTW_W(FTW_W),
                .POW_W(POW_W), .ASF_W(ASF_W)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_ftw(wr_ftw), .wr_pow(wr_pow), .wr_asf(wr_asf),
        .rd_idx(load_idx), .rd_ftw(rd_ftw), .rd_pow(rd_pow), .rd_asf(rd_asf));

    prof_active #(.IDX_W(IDX_W), .FTW_W(FTW_W), .POW_W(POW_W),
                  .ASF_W(ASF_W)) u_active (
        .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_idx(load_idx),
        .in_ftw(rd_ftw), .in_pow(rd_pow), .in_asf(rd_asf),
        .out_ftw(act_ftw), .out_pow(act_pow), .out_asf(act_asf),
        .out_idx(act_idx));

    // R2: active words move only in the cycle flagged by the change pulse
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !prof_chg |-> ($stable(act_ftw) && $stable(act_pow) && $stable(act_asf)));

    // R5: after a transfer the active index matches the synchronized pins
    p_idx_pins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        prof_chg |-> act_idx == $past(sel_sync));

endmodule

// File: tb/test_prof_bank_sel.sv
module test_prof_bank_sel;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [31:0] wr_ftw;
    logic [15:0] wr_pow;
    logic [13:0] wr_asf;
    logic [2:0]  sel_pins;
    logic        upd_in;
    logic [31:0] act_ftw;
    logic [15:0] act_pow;
    logic [13:0] act_asf;
    logic [2:0]  act_idx;
    logic        prof_chg;

    int tests = 0;
    int fails = 0;

    logic [31:0] m_ftw [8];
    logic [15:0] m_pow [8];
    logic [13:0] m_asf [8];

    // [7]=use update strobe, [6:4]=pin code, [2:0]=expected active index
    localparam logic [7:0] VEC_TBL [10] = '{
        8'h11, 8'h33, 8'h77, 8'hF7, 8'h66,
        8'h00, 8'h55, 8'h44, 8'h22, 8'hA2 };

    always #5 clk = ~clk;

    prof_bank_sel i_prof_bank_sel (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_ftw(wr_ftw), .wr_pow(wr_pow), .wr_asf(wr_asf),
        .sel_pins(sel_pins), .upd_in(upd_in),
        .act_ftw(act_ftw), .act_pow(act_pow), .act_asf(act_asf),
        .act_idx(act_idx), .prof_chg(prof_chg));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic chk_set(input string req, input int idx);
        chk(req, act_ftw, m_ftw[idx]);
        chk(req, 32'(act_pow), 32'(m_pow[idx]));
        chk(req, 32'(act_asf), 32'(m_asf[idx]));
        chk(req, 32'(act_idx), 32'(idx));
    endtask

    task automatic write_set(input int idx, input logic [31:0] f,
                             input logic [15:0] p, input logic [13:0] a);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_ftw = f; wr_pow = p; wr_asf = a;
        @(negedge clk);
        wr_en = 1'b0;
        m_ftw[idx] = f; m_pow[idx] = p; m_asf[idx] = a;
    endtask

    // Change pins or raise strobe, sample after the third edge and the fourth
    task automatic xfer(input logic [2:0] pins, input bit use_upd,
                        input int exp_idx, input string req);
        @(negedge clk);
        if (use_upd) upd_in = 1'b1;
        else         sel_pins = pins;
        repeat (3) @(posedge clk);
        #1;
        chk_set(req, exp_idx);
        chk({req, " R6 pulse high"}, 32'(prof_chg), 32'd1);
        @(posedge clk);
        #1;
        chk({req, " R6 pulse one cycle"}, 32'(prof_chg), 32'd0);
        if (use_upd) begin
            @(negedge clk);
            upd_in = 1'b0;
            repeat (4) @(negedge clk);
            chk({req, " R4 falling strobe"}, 32'(prof_chg), 32'd0);
        end
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int pulses;
        rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_ftw = '0; wr_pow = '0;
        wr_asf = '0; sel_pins = '0; upd_in = 1'b0;
        for (int i = 0; i < 8; i++) begin
            m_ftw[i] = '0; m_pow[i] = '0; m_asf[i] = '0;
        end
        repeat (4) @(negedge clk);
        chk("R1 reset ftw", act_ftw, 32'd0);
        chk("R1 reset pulse", 32'(prof_chg), 32'd0);
        rst_n = 1'b1;

        // R9: fill all eight sets with distinct contents
        for (int i = 0; i < 8; i++)
            write_set(i, 32'hA500_0000 ^ (32'h0101_0101 * (i + 1)),
                      16'(16'h1111 * (i + 1)), 14'(14'h0123 * (i + 1)));
        repeat (4) @(negedge clk);
        chk("R2 no transfer yet ftw", act_ftw, 32'd0);
        chk("R1 idx still zero", 32'(act_idx), 32'd0);

        xfer(3'd0, 1'b1, 0, "R3 update loads set 0");

        // R5 R9 table walk through pin codes and strobes
        foreach (VEC_TBL[k]) begin
            xfer(VEC_TBL[k][6:4], VEC_TBL[k][7], int'(VEC_TBL[k][2:0]), "R5 R9 table");
        end

        // R4: hold strobe high, only one pulse
        @(negedge clk);
        upd_in = 1'b1;
        pulses = 0;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            if (prof_chg) pulses++;
        end
        chk("R4 held strobe pulses", 32'(pulses), 32'd1);
        upd_in = 1'b0;
        pulses = 0;
        for (int c = 0; c < 8; c++) begin
            @(negedge clk);
            if (prof_chg) pulses++;
        end
        chk("R4 falling strobe pulses", 32'(pulses), 32'd0);

        // R2: rewrite the active set, outputs wait for the strobe
        write_set(2, 32'h1234_5678, 16'hBEEF, 14'h1ABC);
        repeat (5) @(negedge clk);
        chk("R2 held ftw", act_ftw, 32'hA500_0000 ^ (32'h0101_0101 * 3));
        xfer(3'd2, 1'b1, 2, "R2 after strobe");

        // R7: staging write captured on the load edge
        @(negedge clk);
        sel_pins = 3'd5;
        repeat (2) @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd5; wr_ftw = 32'hDEAD_0005;
        wr_pow = 16'h0505; wr_asf = 14'h0055;
        @(posedge clk);
        #1;
        chk_set("R7 pre-write value", 5);
        @(negedge clk);
        wr_en = 1'b0;
        m_ftw[5] = 32'hDEAD_0005; m_pow[5] = 16'h0505; m_asf[5] = 14'h0055;
        xfer(3'd5, 1'b1, 5, "R7 new value staged");

        // R8: two-tone keying on the lowest pin
        xfer(3'd0, 1'b0, 0, "R8 space");
        for (int t = 0; t < 4; t++) begin
            xfer(3'(((t + 1) % 2)), 1'b0, (t + 1) % 2, "R8 toggle");
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule